// File: doc/BRIEF.md
# Single-Level Fixed-Priority Interrupt Controller

This block sits next to a processor core and turns six request lines into one interrupt entry at a time. Two of the lines come from outside the chip. They are synchronized and then edge detected. The other four come from on-chip units, such as the serial receiver reporting a full input buffer and the serial transmitter reporting an empty output buffer. Every request is latched as pending, and each source has its own enable bit. When the core is not already servicing an interrupt, the controller picks the enabled pending source with the lowest index. It then pulses `take_o` for one cycle, which tells the core to save its machine state and accumulators and to jump.

With that pulse the controller presents the source index and the jump address. The address is a table base plus the index times the size of one table slot, and one slot holds two branch instructions. The controller then refuses every further entry until the core signals a return through `rti_i`. On that return it pulses `restore_o` so that the core reloads its saved context. Service is strictly single level and never nests.

Top module: `irq_ctrl`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it is released, `take_o`, `restore_o` and `in_service_o` are 0 and `vec_idx_o` and `vec_addr_o` are 0.
- R2: A 1 on an internal line `int_irq_i[k]` at a rising edge marks source index N_EXT+k as pending. If that source is enabled and no service is active, `take_o` is high after the next rising edge.
- R3: An external line `ext_irq_i[j]` (source index j) passes through two synchronizer stages. Only a 0-to-1 transition marks it pending, so a line held high produces a single request. `take_o` follows the input change after four rising edges.
- R4: A source whose bit in `irq_en_i` is 0 (1 enables) stays pending but is never taken. Once its enable bit is 1 and no service is active, it is taken on the next edge.
- R5: Among enabled pending sources, the lowest index wins. The external sources hold indices 0 and 1, and the internal sources hold indices 2 to 5.
- R6: `vec_idx_o` gives the selected index and `vec_addr_o` equals VEC_BASE + index*8, where one slot is 2 words of 4 bytes. Both change only in the cycle that `take_o` is high and hold until the next entry.
- R7: While `in_service_o` is high, no further `take_o` is issued, whatever is pending or enabled.
- R8: Entry clears the pending bit of the selected source on the same edge that raises `take_o`. A request for that same source arriving at that edge keeps it pending.
- R9: `rti_i` sampled high while `in_service_o` is high clears `in_service_o` and gives a one-cycle `restore_o` after the same edge. `rti_i` while idle has no effect.
- R10: `take_o` is a one-cycle pulse, and `in_service_o` rises in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | N_EXT | Asynchronous external request lines, rising-edge sensitive |
| int_irq_i | input | N_INT | Internal request lines, sampled each edge |
| irq_en_i | input | N_EXT+N_INT | Per-source enable, 1 allows entry |
| rti_i | input | 1 | Return-from-interrupt indication from the core |
| take_o | output | 1 | One-cycle entry pulse: save context and jump |
| vec_idx_o | output | $clog2(N_EXT+N_INT) | Index of the source taken |
| vec_addr_o | output | ADDR_W | Vector table address of the source taken |
| in_service_o | output | 1 | High from entry until return |
| restore_o | output | 1 | One-cycle pulse: restore saved context |

## Verification
The latencies fixed by the requirements are:

- An internal request raises `take_o` two edges after it is driven.
- An external transition needs four edges: two synchronizer stages, the edge detector and the entry register.
- Enabling a source that is already pending, or returning through `rti_i`, acts on the very next edge.

The bench drives inputs at falling edges. It advances its own cycle model on each rising edge, which gives the model the same register depth as these latencies. It then compares every output 1 ns after that edge, so each result is checked in exactly the cycle it is due and in no other.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

  typedef enum logic [0:0] {
    SVC_IDLE = 1'b0,
    SVC_BUSY = 1'b1
  } svc_state_e;

  // address of a vector slot
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input logic [31:0] idx,
                                            input logic [31:0] stride);
    return base + idx * stride;
  endfunction

endpackage

// File: rtl/irq_sync_edge.sv
`timescale 1ns/1ps
module irq_sync_edge #(
  parameter int N_LINES = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] async_i,
  output logic [N_LINES-1:0] rise_o
);

  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [DEPTH-1:0] shift_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shift_q <= '0;
      else         shift_q <= {shift_q[DEPTH-2:0], async_i[g]};
    end

    // last sync stage high, history stage low
    assign rise_o[g] = shift_q[STAGES-1] & ~shift_q[STAGES];
  end

endmodule

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
module irq_pending #(
  parameter int N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);

  logic [N_SRC-1:0] pend_q;

  // new request outranks the clear of an entry on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int N_REQ = 6,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  logic [N_REQ-1:0] above;

  assign above[0] = 1'b0;
  for (genvar g = 1; g < N_REQ; g++) begin : g_chain
    assign above[g] = above[g-1] | req_i[g-1];
  end

  assign grant_o = req_i & ~above;
  assign any_o   = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (grant_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int           N_EXT       = 2,
  parameter int           N_INT       = 4,
  parameter int           SYNC_STAGES = 2,
  parameter int           ADDR_W      = 24,
  parameter int           ENTRY_WORDS = 2,
  parameter int           WORD_BYTES  = 4,
  parameter logic [31:0]  VEC_BASE    = 32'h0000_0100,
  localparam int          N_SRC       = N_EXT + N_INT,
  localparam int          IDX_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic [N_INT-1:0]  int_irq_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  input  logic              rti_i,
  output logic              take_o,
  output logic [IDX_W-1:0]  vec_idx_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              in_service_o,
  output logic              restore_o
);

  localparam logic [31:0] STRIDE = 32'(ENTRY_WORDS * WORD_BYTES);

  logic [N_EXT-1:0]  ext_rise;
  logic [N_SRC-1:0]  set_req, clr_req, pend, cand, grant;
  logic [IDX_W-1:0]  sel_idx;
  logic              cand_any, take_now, rti_hit;
  svc_state_e        state_q, state_d;
  logic              take_q, restore_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  irq_sync_edge #(
    .N_LINES (N_EXT),
    .STAGES  (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_irq_i),
    .rise_o  (ext_rise)
  );

  // external sources take the top-priority indices
  assign set_req = {int_irq_i, ext_rise};

  irq_pending #(
    .N_SRC (N_SRC)
  ) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_req),
    .clr_i  (clr_req),
    .pend_o (pend)
  );

  assign cand = pend & irq_en_i;

  irq_prio_enc #(
    .N_REQ (N_SRC)
  ) u_prio (
    .req_i   (cand),
    .grant_o (grant),
    .idx_o   (sel_idx),
    .any_o   (cand_any)
  );

  assign take_now = (state_q == SVC_IDLE) && cand_any;
  assign rti_hit  = (state_q == SVC_BUSY) && rti_i;
  assign clr_req  = take_now ? grant : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SVC_IDLE: if (take_now) state_d = SVC_BUSY;
      SVC_BUSY: if (rti_i)    state_d = SVC_IDLE;
      default:                state_d = SVC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SVC_IDLE;
      take_q    <= 1'b0;
      restore_q <= 1'b0;
      idx_q     <= '0;
      addr_q    <= '0;
    end else begin
      state_q   <= state_d;
      take_q    <= take_now;
      restore_q <= rti_hit;
      if (take_now) begin
        idx_q  <= sel_idx;
        addr_q <= ADDR_W'(slot_addr(VEC_BASE, 32'(sel_idx), STRIDE));
      end
    end
  end

  assign take_o       = take_q;
  assign restore_o    = restore_q;
  assign in_service_o = (state_q == SVC_BUSY);
  assign vec_idx_o    = idx_q;
  assign vec_addr_o   = addr_q;

endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int          N_SRC    = 6,
  parameter int          IDX_W    = 3,
  parameter int          ADDR_W   = 24,
  parameter logic [31:0] VEC_BASE = 32'h0000_0100,
  parameter logic [31:0] STRIDE   = 32'd8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  irq_en_i,
  input logic              take_o,
  input logic [IDX_W-1:0]  vec_idx_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              in_service_o,
  input logic              restore_o
);

  logic             past_ok;
  logic [N_SRC-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      en_q    <= '0;
    end else begin
      past_ok <= 1'b1;
      en_q    <= irq_en_i;
    end
  end

  assert_take_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_take_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> in_service_o);

  assert_single_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_service_o |=> !take_o);

  assert_restore_after_svc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && restore_o) |-> (!in_service_o && $past(in_service_o)));

  assert_vec_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !take_o) |-> ($stable(vec_idx_o) && $stable(vec_addr_o)));

  assert_vec_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (32'(vec_addr_o) == ((VEC_BASE + 32'(vec_idx_o) * STRIDE) & 32'((64'd1 << ADDR_W) - 1))));

  assert_enabled_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && take_o) |-> en_q[vec_idx_o]);

  assert_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(vec_idx_o) < N_SRC);

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .N_SRC    (N_SRC),
  .IDX_W    (IDX_W),
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_BASE),
  .STRIDE   (32'(ENTRY_WORDS * WORD_BYTES))
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_en_i     (irq_en_i),
  .take_o       (take_o),
  .vec_idx_o    (vec_idx_o),
  .vec_addr_o   (vec_addr_o),
  .in_service_o (in_service_o),
  .restore_o    (restore_o)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;

  localparam int          N_EXT  = 2;
  localparam int          N_INT  = 4;
  localparam int          N_SRC  = 6;
  localparam int          IDX_W  = 3;
  localparam int          ADDR_W = 24;
  localparam logic [31:0] BASE   = 32'h0000_0100;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_EXT-1:0]  ext_irq = '0;
  logic [N_INT-1:0]  int_irq = '0;
  logic [N_SRC-1:0]  irq_en = '0;
  logic              rti = 1'b0;
  logic              take;
  logic [IDX_W-1:0]  vec_idx;
  logic [ADDR_W-1:0] vec_addr;
  logic              in_svc;
  logic              restore;

  always #2.5 clk = ~clk;

  irq_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ext_irq_i    (ext_irq),
    .int_irq_i    (int_irq),
    .irq_en_i     (irq_en),
    .rti_i        (rti),
    .take_o       (take),
    .vec_idx_o    (vec_idx),
    .vec_addr_o   (vec_addr),
    .in_service_o (in_svc),
    .restore_o    (restore)
  );

  int errors = 0;
  int checks = 0;
  int n_take = 0;
  bit done = 1'b0;

  // bench model
  logic [N_EXT-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
  logic [N_SRC-1:0] m_pend = '0;
  logic             m_svc = 1'b0, m_take = 1'b0, m_rest = 1'b0;
  logic [IDX_W-1:0] m_idx = '0;
  logic [ADDR_W-1:0] m_addr = '0;

  function automatic logic [ADDR_W-1:0] exp_addr(input int idx);
    return ADDR_W'(BASE + 32'(idx) * 32'd8);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [N_INT-1:0] iv, input logic [N_EXT-1:0] ev,
                            input logic [N_SRC-1:0] env, input logic rv);
    logic [N_SRC-1:0] set_v, cand, clr;
    int sel;
    bit tk;
    set_v = {iv, m_s2 & ~m_s3};
    cand  = m_pend & env;
    tk    = !m_svc && (cand != '0);
    sel   = 0;
    for (int i = N_SRC - 1; i >= 0; i--) if (cand[i]) sel = i;
    clr = tk ? (N_SRC'(1) << sel) : '0;
    m_rest = rv && m_svc;
    if (tk) begin
      m_svc  = 1'b1;
      m_idx  = IDX_W'(sel);
      m_addr = exp_addr(sel);
    end else if (m_svc && rv) begin
      m_svc = 1'b0;
    end
    m_take = tk;
    m_pend = (m_pend & ~clr) | set_v;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ev;
  endtask

  task automatic compare(input string tag);
    check(take === m_take, tag, "take_o (R10)", 32'(take), 32'(m_take));
    check(in_svc === m_svc, tag, "in_service_o (R7)", 32'(in_svc), 32'(m_svc));
    check(restore === m_rest, tag, "restore_o (R9)", 32'(restore), 32'(m_rest));
    check(vec_idx === m_idx, tag, "vec_idx_o (R5)", 32'(vec_idx), 32'(m_idx));
    check(vec_addr === m_addr, tag, "vec_addr_o (R6)", 32'(vec_addr), 32'(m_addr));
    if (take === 1'b1) n_take++;
  endtask

  task automatic step(input logic [N_INT-1:0] iv, input logic [N_EXT-1:0] ev,
                      input logic [N_SRC-1:0] env, input logic rv, input string tag);
    @(negedge clk);
    int_irq = iv; ext_irq = ev; irq_en = env; rti = rv;
    @(posedge clk);
    model_edge(iv, ev, env, rv);
    #1;
    compare(tag);
  endtask

  task automatic idle(input int n, input logic [N_SRC-1:0] env, input string tag);
    for (int i = 0; i < n; i++) step('0, ext_irq, env, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int t0;
    logic [N_SRC-1:0] en_r;
    logic [N_EXT-1:0] ex_r;
    void'($urandom(32'h1a2b));

    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check({take, restore, in_svc} === 3'b000, "R1", "flags in reset", 32'({take, restore, in_svc}), 0);
    check(vec_addr === '0 && vec_idx === '0, "R1", "vector in reset", 32'(vec_addr), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    step('0, '0, '1, 1'b0, "R1");

    // R2 internal latency: take after the following edge
    step(4'b0001, '0, '1, 1'b0, "R2");
    step('0, '0, '1, 1'b0, "R2");
    check(take === 1'b1 && vec_idx === 3'd2, "R2", "take next edge idx", 32'(vec_idx), 2);
    idx_chk: check(vec_addr === exp_addr(2), "R6", "slot address", 32'(vec_addr), 32'(exp_addr(2)));
    idle(3, '1, "R7");
    step('0, '0, '1, 1'b1, "R9");
    check(restore === 1'b1 && in_svc === 1'b0, "R9", "return", 32'({restore, in_svc}), 2);

    // R9 rti while idle ignored
    step('0, '0, '1, 1'b1, "R9");
    check(restore === 1'b0 && in_svc === 1'b0, "R9", "idle rti ignored", 32'({restore, in_svc}), 0);

    // R3 external held high: one take, 4 edges
    t0 = n_take;
    step('0, 2'b01, '1, 1'b0, "R3");
    step('0, 2'b01, '1, 1'b0, "R3");
    step('0, 2'b01, '1, 1'b0, "R3");
    check(take === 1'b0, "R3", "no take before 4th edge", 32'(take), 0);
    step('0, 2'b01, '1, 1'b0, "R3");
    check(take === 1'b1 && vec_idx === 3'd0, "R3", "take at 4th edge", 32'({take, vec_idx}), 32'h8);
    idle(2, '1, "R3");
    step('0, 2'b01, '1, 1'b1, "R9");
    idle(8, '1, "R3");
    check(n_take - t0 == 1, "R3", "held level takes", 32'(n_take - t0), 1);
    step('0, 2'b00, '1, 1'b0, "R3");

    // R4 masked stays pending
    step(4'b0100, '0, 6'b101111, 1'b0, "R4");
    idle(5, 6'b101111, "R4");
    check(in_svc === 1'b0, "R4", "masked not taken", 32'(in_svc), 0);
    step('0, '0, '1, 1'b0, "R4");
    check(take === 1'b1 && vec_idx === 3'd4, "R4", "unmasked taken", 32'(vec_idx), 4);
    step('0, '0, '1, 1'b1, "R9");

    // R5 priority with all internal at once; R7 blocks while busy
    step(4'b1111, '0, '1, 1'b0, "R5");
    step('0, '0, '1, 1'b0, "R5");
    check(vec_idx === 3'd2, "R5", "lowest index first", 32'(vec_idx), 2);
    idle(4, '1, "R7");
    for (int k = 3; k <= 5; k++) begin
      step('0, '0, '1, 1'b1, "R9");
      step('0, '0, '1, 1'b0, "R5");
      check(vec_idx === 3'(k), "R5", "next in order", 32'(vec_idx), 32'(k));
    end
    step('0, '0, '1, 1'b1, "R9");

    // R8 request at the entry edge stays pending
    step(4'b0010, '0, '1, 1'b0, "R8");
    step(4'b0010, '0, '1, 1'b0, "R8");
    step('0, '0, '1, 1'b1, "R8");
    step('0, '0, '1, 1'b0, "R8");
    check(take === 1'b1 && vec_idx === 3'd3, "R8", "re-set source taken again", 32'({take, vec_idx}), 32'hB);
    step('0, '0, '1, 1'b1, "R9");
    idle(3, '1, "R8");

    // random traffic
    en_r = '1;
    ex_r = '0;
    for (int c = 0; c < 4000; c++) begin
      logic [N_INT-1:0] iv;
      iv = '0;
      for (int b = 0; b < N_INT; b++) iv[b] = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 9) == 0) ex_r = ex_r ^ N_EXT'($urandom_range(1, 3));
      if ($urandom_range(0, 49) == 0) en_r = N_SRC'($urandom);
      step(iv, ex_r, en_r, ($urandom_range(0, 5) == 0), "R5");
    end
    idle(10, '1, "R2");

    finish_run();
  end

endmodule